// File: doc/BRIEF.md
# TDMA Slot Schedule Sequencer

This block paces a time-division bus schedule. It counts macroticks against a static schedule that software or a configuration engine loads beforehand. The schedule fixes how many slots form one round and how many rounds form one cluster cycle. For every slot it also holds the node allowed to transmit, the slot's length in macroticks, and the length of the transmission phase inside that slot.

When the slot timing is running, the sequencer marks the start of every slot with one trigger. It issues a send trigger when the local node owns the slot and a receive trigger when another node owns it. It issues a separate end-of-transmission-phase trigger once the configured phase has elapsed inside the slot. The current slot and round indices are always visible, so a controller can follow its position in the cycle. Timing begins with the first macrotick after the run command rises, which lets the sequencer start during cluster startup. Dropping the run command returns everything to the beginning of the cycle.

Top module: `tdma_slot_sequencer`

## Requirements
- R1: While `rst` is high, or on any clock edge where `run` is low, the slot index and the round index return to 0 and all three trigger outputs are low in the following cycle.
- R2: After `run` rises, nothing happens until the first `mt_tick`. That tick enters slot 0 of round 0 and raises a slot-start trigger in the next cycle.
- R3: A slot whose descriptor holds length L spans exactly L macroticks. The next slot-start trigger follows the L-th tick counted from the tick that started the slot.
- R4: Every slot start raises exactly one of `send_stb` or `recv_stb`. `send_stb` is chosen when the slot's owner field equals `node_id`, and `recv_stb` is chosen otherwise. The two are never high together.
- R5: `eotp_stb` is raised on the tick that falls P macroticks after the slot start, where P is the slot's phase length (1 ≤ P ≤ L). When P equals L, it coincides with the start trigger of the next slot.
- R6: After the last slot of a round, which has index `geo_last_slot`, the slot index wraps to 0 and the round index increments. The round index changes only together with a slot-start trigger for slot 0.
- R7: After the last slot of the round whose index is `geo_last_round`, the round index wraps to 0.
- R8: Each trigger is a single-cycle pulse in the cycle after a clock edge that sampled `mt_tick` high with `run` high. Cycles without a tick leave the indices unchanged and all triggers low.
- R9: A clock edge with `tbl_we` high stores `tbl_owner`, `tbl_slot_len` and `tbl_tp_len` as the descriptor of slot `tbl_idx`. A clock edge with `geo_we` high stores the last slot index and the last round index. After reset, every descriptor holds owner 0, length 1 and phase 1, and both last indices are 0.
- R10: Lowering `run` in the middle of a cycle and raising it again restarts the schedule at slot 0 of round 0 on the next tick. The start trigger is classed by the current owner of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Start/enable command; low holds the sequencer at the cycle origin |
| mt_tick | input | 1 | Macrotick strobe, one cycle per macrotick |
| node_id | input | 4 | Local node identity |
| tbl_we | input | 1 | Descriptor write enable |
| tbl_idx | input | IDX_W | Slot index to write |
| tbl_owner | input | 4 | Owning node of the slot |
| tbl_slot_len | input | 8 | Slot length in macroticks (≥1) |
| tbl_tp_len | input | 8 | Transmission-phase length in macroticks (1..slot length) |
| geo_we | input | 1 | Geometry write enable |
| geo_last_slot | input | IDX_W | Slots per round minus one |
| geo_last_round | input | 3 | Rounds per cluster cycle minus one |
| send_stb | output | 1 | Slot start, local node transmits |
| recv_stb | output | 1 | Slot start, another node transmits |
| eotp_stb | output | 1 | End of the current transmission phase |
| slot_idx | output | IDX_W | Current slot within the round |
| round_idx | output | 3 | Current round within the cluster cycle |

## Verification
The hardest case to reach from the ports is the case where a phase end lands exactly on a slot boundary, so that `eotp_stb` and the next start trigger share one cycle. A nearby hard case is the double wrap, where the slot and round indices roll over on the same tick. The stimulus sweeps several generated schedules whose lengths and phases are computed so that some slots have a phase equal to their length. Each schedule has one to four slots, one to three rounds and mixed owners. Each schedule runs for two full cluster cycles, with ticks on every cycle for some schedules and on every second cycle for others. Each schedule ends with a stop in mid-cycle and a restart after the owner of slot 0 has been rewritten.

// File: rtl/tdma_seq_pkg.sv
package tdma_seq_pkg;

    localparam int NODE_W  = 4;
    localparam int LEN_W   = 8;
    localparam int ROUND_W = 3;

    typedef logic [NODE_W-1:0]  node_id_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [ROUND_W-1:0] round_t;

    typedef struct packed {
        node_id_t owner;
        len_t     slot_len;
        len_t     tp_len;
    } slot_desc_t;

    typedef struct packed {
        logic send;
        logic recv;
        logic eotp;
    } slot_evt_t;

    localparam slot_desc_t DESC_RESET = '{owner: '0, slot_len: len_t'(1), tp_len: len_t'(1)};

    // true when the incremented in-slot count matches a programmed length
    function automatic logic count_hits(input len_t pos, input len_t target);
        logic [LEN_W:0] nxt;
        nxt = {1'b0, pos} + {{LEN_W{1'b0}}, 1'b1};
        return nxt == {1'b0, target};
    endfunction

endpackage

// File: rtl/tdma_desc_table.sv
module tdma_desc_table
    import tdma_seq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_desc_t       wr_desc,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic [IDX_W-1:0] rd_b_idx,
    output slot_desc_t       rd_a,
    output slot_desc_t       rd_b
);

    slot_desc_t ents [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_ent
        slot_desc_t ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= DESC_RESET;
            else if (wr_en && (int'(wr_idx) == g))
                ent_q <= wr_desc;
        end
        assign ents[g] = ent_q;
    end

    always_comb begin
        rd_a = DESC_RESET;
        rd_b = DESC_RESET;
        if (int'(rd_a_idx) < SLOTS) rd_a = ents[rd_a_idx];
        if (int'(rd_b_idx) < SLOTS) rd_b = ents[rd_b_idx];
    end

endmodule

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer
    import tdma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  len_t slot_len,
    input  len_t tp_len,
    output logic slot_end,
    output logic tp_end
);

    len_t pos_q;

    assign slot_end = count_hits(pos_q, slot_len);
    assign tp_end   = count_hits(pos_q, tp_len);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pos_q <= '0;
        else if (step)
            pos_q <= slot_end ? '0 : pos_q + len_t'(1);
    end

endmodule

// File: rtl/tdma_index_ctr.sv
module tdma_index_ctr
    import tdma_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    input  logic [IDX_W-1:0] last_slot,
    input  round_t           last_round,
    output logic [IDX_W-1:0] slot_q,
    output round_t           round_q,
    output logic [IDX_W-1:0] nxt_slot,
    output round_t           nxt_round
);

    logic round_done;

    assign round_done = (slot_q == last_slot);
    assign nxt_slot   = round_done ? '0 : slot_q + {{(IDX_W-1){1'b0}}, 1'b1};

    always_comb begin
        nxt_round = round_q;
        if (round_done)
            nxt_round = (round_q == last_round) ? '0 : round_q + round_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            slot_q  <= '0;
            round_q <= '0;
        end else if (adv) begin
            slot_q  <= nxt_slot;
            round_q <= nxt_round;
        end
    end

endmodule

// File: rtl/tdma_slot_sequencer.sv
module tdma_slot_sequencer
    import tdma_seq_pkg::*;
#(
    parameter  int SLOTS = 8,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             mt_tick,
    input  node_id_t         node_id,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  node_id_t         tbl_owner,
    input  len_t             tbl_slot_len,
    input  len_t             tbl_tp_len,
    input  logic             geo_we,
    input  logic [IDX_W-1:0] geo_last_slot,
    input  round_t           geo_last_round,
    output logic             send_stb,
    output logic             recv_stb,
    output logic             eotp_stb,
    output logic [IDX_W-1:0] slot_idx,
    output round_t           round_idx
);

    logic [IDX_W-1:0] last_slot_q;
    round_t           last_round_q;
    logic             active_q;
    slot_evt_t        evt_q, evt_d;

    logic             start_now, step, enter, clr;
    logic             slot_end, tp_end;
    logic [IDX_W-1:0] nxt_slot, enter_idx;
    round_t           nxt_round;
    slot_desc_t       cur_desc, enter_desc, wr_desc;

    assign clr       = ~run;
    assign start_now = run & mt_tick & ~active_q;
    assign step      = run & mt_tick & active_q;
    assign enter     = start_now | (step & slot_end);
    assign enter_idx = start_now ? '0 : nxt_slot;
    assign wr_desc   = '{owner: tbl_owner, slot_len: tbl_slot_len, tp_len: tbl_tp_len};

    always_ff @(posedge clk) begin
        if (rst) begin
            last_slot_q  <= '0;
            last_round_q <= '0;
        end else if (geo_we) begin
            last_slot_q  <= geo_last_slot;
            last_round_q <= geo_last_round;
        end
    end

    tdma_desc_table #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_desc  (wr_desc),
        .rd_a_idx (slot_idx),
        .rd_b_idx (enter_idx),
        .rd_a     (cur_desc),
        .rd_b     (enter_desc)
    );

    tdma_slot_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .step     (step),
        .slot_len (cur_desc.slot_len),
        .tp_len   (cur_desc.tp_len),
        .slot_end (slot_end),
        .tp_end   (tp_end)
    );

    tdma_index_ctr #(.IDX_W(IDX_W)) u_index (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .adv        (step & slot_end),
        .last_slot  (last_slot_q),
        .last_round (last_round_q),
        .slot_q     (slot_idx),
        .round_q    (round_idx),
        .nxt_slot   (nxt_slot),
        .nxt_round  (nxt_round)
    );

    always_comb begin
        evt_d.send = enter & (enter_desc.owner == node_id);
        evt_d.recv = enter & (enter_desc.owner != node_id);
        evt_d.eotp = step & tp_end;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            active_q <= 1'b0;
            evt_q    <= '0;
        end else begin
            if (start_now) active_q <= 1'b1;
            evt_q <= evt_d;
        end
    end

    assign send_stb = evt_q.send;
    assign recv_stb = evt_q.recv;
    assign eotp_stb = evt_q.eotp;

endmodule

// File: rtl/tdma_seq_chk.sv
module tdma_seq_chk
    import tdma_seq_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             mt_tick,
    input logic             send_stb,
    input logic             recv_stb,
    input logic             eotp_stb,
    input logic [IDX_W-1:0] slot_idx,
    input round_t           round_idx
);

    AST_ONE_START_KIND: assert property (@(posedge clk) disable iff (rst)
        !(send_stb && recv_stb)); // R4

    AST_TRIGGER_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        (send_stb || recv_stb || eotp_stb) |-> ($past(mt_tick) && $past(run))); // R8

    AST_STOP_TO_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!send_stb && !recv_stb && !eotp_stb && slot_idx == '0 && round_idx == '0)); // R1

    AST_SLOT_MOVES_WITH_START: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && slot_idx != $past(slot_idx)) |-> (send_stb || recv_stb)); // R3

    AST_ROUND_MOVES_AT_SLOT0: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && round_idx != $past(round_idx)) |-> (slot_idx == '0 && (send_stb || recv_stb))); // R6

endmodule

bind tdma_slot_sequencer tdma_seq_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .mt_tick   (mt_tick),
    .send_stb  (send_stb),
    .recv_stb  (recv_stb),
    .eotp_stb  (eotp_stb),
    .slot_idx  (slot_idx),
    .round_idx (round_idx)
);

// File: tb/tdma_slot_sequencer_tb_top.sv
module tdma_slot_sequencer_tb_top;
    import tdma_seq_pkg::*;

    localparam int SLOTS = 4;
    localparam int IDX_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run = 1'b0;
    logic             mt_tick = 1'b0;
    node_id_t         node_id = '0;
    logic             tbl_we = 1'b0;
    logic [IDX_W-1:0] tbl_idx = '0;
    node_id_t         tbl_owner = '0;
    len_t             tbl_slot_len = '0;
    len_t             tbl_tp_len = '0;
    logic             geo_we = 1'b0;
    logic [IDX_W-1:0] geo_last_slot = '0;
    round_t           geo_last_round = '0;
    logic             send_stb, recv_stb, eotp_stb;
    logic [IDX_W-1:0] slot_idx;
    round_t           round_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int lens [SLOTS];
    int tps  [SLOTS];
    int owns [SLOTS];
    int exp_slot = 0;
    int exp_round = 0;

    always #10 clk = ~clk;

    tdma_slot_sequencer #(.SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst(rst), .run(run), .mt_tick(mt_tick), .node_id(node_id),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_owner(tbl_owner),
        .tbl_slot_len(tbl_slot_len), .tbl_tp_len(tbl_tp_len),
        .geo_we(geo_we), .geo_last_slot(geo_last_slot), .geo_last_round(geo_last_round),
        .send_stb(send_stb), .recv_stb(recv_stb), .eotp_stb(eotp_stb),
        .slot_idx(slot_idx), .round_idx(round_idx)
    );

    task automatic expect_eq(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic one_cycle(input logic t);
        mt_tick = t;
        @(posedge clk);
        @(negedge clk);
        mt_tick = 1'b0;
    endtask

    task automatic check_all(input string req, input int s, input int r, input int snd, input int rcv, input int eot);
        expect_eq(req, "slot_idx", int'(slot_idx), s);
        expect_eq(req, "round_idx", int'(round_idx), r);
        expect_eq(req, "send_stb", int'(send_stb), snd);
        expect_eq(req, "recv_stb", int'(recv_stb), rcv);
        expect_eq(req, "eotp_stb", int'(eotp_stb), eot);
    endtask

    task automatic write_desc(input int idx, input int own, input int len, input int tp);
        tbl_we = 1'b1;
        tbl_idx = IDX_W'(idx);
        tbl_owner = node_id_t'(own);
        tbl_slot_len = len_t'(len);
        tbl_tp_len = len_t'(tp);
        @(posedge clk);
        @(negedge clk);
        tbl_we = 1'b0;
        lens[idx] = len;
        tps[idx] = tp;
        owns[idx] = own;
    endtask

    task automatic write_geo(input int ls, input int lr);
        geo_we = 1'b1;
        geo_last_slot = IDX_W'(ls);
        geo_last_round = round_t'(lr);
        @(posedge clk);
        @(negedge clk);
        geo_we = 1'b0;
    endtask

    task automatic run_config(input int cfg);
        int ns, nr, gap, round_len, cyc, nticks;
        ns  = 1 + cfg % 4;
        nr  = 1 + (cfg * 2) % 3;
        gap = (cfg % 2 == 1) ? 2 : 1;
        node_id = node_id_t'(cfg % 3);
        for (int k = 0; k < ns; k++) begin
            int len;
            len = 1 + (cfg * 3 + k * 5) % 6;
            write_desc(k, (k + cfg) % 4, len, 1 + (cfg + 2 * k) % len);
        end
        write_geo(ns - 1, nr - 1);
        round_len = 0;
        for (int k = 0; k < ns; k++) round_len += lens[k];
        cyc = round_len * nr;
        nticks = 2 * cyc + 2;

        // R8 R1: ticks with run low do nothing
        one_cycle(1'b1);
        check_all("R1 R8 idle", 0, 0, 0, 0, 0);
        // R2: run high but no tick yet
        run = 1'b1;
        one_cycle(1'b0);
        check_all("R2 wait", 0, 0, 0, 0, 0);

        exp_slot = 0;
        exp_round = 0;
        for (int t = 0; t < nticks; t++) begin
            int m, r, w, acc, k, pos, prv, st, eot;
            for (int g = 1; g < gap; g++) begin
                one_cycle(1'b0);
                check_all("R8 gap", exp_slot, exp_round, 0, 0, 0);
            end
            one_cycle(1'b1);
            m = t % cyc;
            r = m / round_len;
            w = m % round_len;
            acc = 0;
            k = 0;
            while (w >= acc + lens[k]) begin
                acc += lens[k];
                k++;
            end
            pos = w - acc;
            prv = (k == 0) ? ns - 1 : k - 1;
            st  = (pos == 0) ? 1 : 0;
            eot = ((pos != 0 && pos == tps[k]) || (pos == 0 && t > 0 && tps[prv] == lens[prv])) ? 1 : 0;
            exp_slot = k;
            exp_round = r;
            if (t == 0) begin
                check_all("R2 first", k, r, (owns[k] == cfg % 3) ? 1 : 0, (owns[k] != cfg % 3) ? 1 : 0, 0);
            end else begin
                expect_eq("R6 R7", "slot_idx", int'(slot_idx), k);
                expect_eq("R6 R7", "round_idx", int'(round_idx), r);
                expect_eq("R3 R4", "send_stb", int'(send_stb), (st == 1 && owns[k] == cfg % 3) ? 1 : 0);
                expect_eq("R3 R4", "recv_stb", int'(recv_stb), (st == 1 && owns[k] != cfg % 3) ? 1 : 0);
                expect_eq("R5", "eotp_stb", int'(eotp_stb), eot);
            end
        end

        // R10: stop mid-cycle, change owner of slot 0, restart
        run = 1'b0;
        one_cycle(1'b0);
        check_all("R10 stop", 0, 0, 0, 0, 0);
        write_desc(0, (cfg % 2 == 0) ? cfg % 3 : (cfg % 3) + 1, lens[0], tps[0]);
        run = 1'b1;
        one_cycle(1'b1);
        check_all("R9 R10 restart", 0, 0, (cfg % 2 == 0) ? 1 : 0, (cfg % 2 == 0) ? 0 : 1, 0);
        run = 1'b0;
        one_cycle(1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_all("R1 reset", 0, 0, 0, 0, 0);
        // R9: reset descriptors (owner 0, length 1, phase 1) with node 0: send every tick
        run = 1'b1;
        node_id = '0;
        one_cycle(1'b1);
        check_all("R9 default", 0, 0, 1, 0, 0);
        one_cycle(1'b1);
        check_all("R9 default R5", 0, 0, 1, 0, 1);
        run = 1'b0;
        one_cycle(1'b0);
        for (int cfg = 0; cfg < 8; cfg++) run_config(cfg);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule